// File: doc/BRIEF.md
# EEE Port Qualification

This block sits beside a three-port switch and decides, port by port, whether Energy Efficient Ethernet low-power-idle signaling may run. Each port has its own rule. The first port depends only on its interface mode and on the duplex reported by its emulated PHY. The second port qualifies only when it sits behind its attached internal PHY. The third port qualifies behind its own PHY or in MII-MAC mode.

For the two PHY-backed ports, the block also requires a stable link. The link must have stayed up without a break for one second, measured by counting a 1 kHz tick input. A per-port software enable and an internal reset gate complete the decision. All three outputs are level signals, and they react in the same cycle that any qualifying input changes.

The interface mode fields share one encoding: 0 internal PHY, 1 MII MAC, 2 MII PHY, 3 RMII MAC, 4 RMII PHY. Codes 5 to 7 are reserved and never qualify.

Top module: `eee_qual`

## Requirements
- R1: `eee_allowed[0]` is high exactly when `sw_en[0]` is high, `p0_mode` is 1 (MII MAC) and `p0_vphy_fdx` is high. Ticks and the inputs of the other ports have no effect on it.
- R2: `eee_allowed[0]` stays low for every `p0_mode` other than 1, including the reserved codes 5 to 7.
- R3: `eee_allowed[1]` is high exactly when all of the following hold: `sw_en[1]` is high, `p1_mode` is 0 (internal PHY), `p1_spd100`, `p1_fdx`, `p1_lcl_eee` and `p1_lp_eee` are high, and the port-1 link is stable.
- R4: `eee_allowed[2]` follows the same rule as R3 with port-2 inputs, except that `p2_mode` may be either 0 (internal PHY) or 1 (MII MAC).
- R5: A low `sw_en[i]` forces `eee_allowed[i]` low on every port.
- R6: A port's link counts as stable only after `TICK_LIMIT` cycles with `tick_1khz` high, all seen while its link input was high. Ticks that arrive while the link is down are not counted, and cycles without a tick do not advance the count.
- R7: When a link input goes low, that port's `eee_allowed` falls in the same cycle. Its count restarts from zero, so a full `TICK_LIMIT` ticks are needed again after the link returns.
- R8: Once the count reaches `TICK_LIMIT`, it holds there. Further ticks keep the port qualified.
- R9: While `rst_n` is low, all three `eee_allowed` bits are low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1khz | input | 1 | One-cycle pulse each millisecond |
| sw_en | input | 3 | Software EEE enable, one bit per port |
| p0_mode | input | 3 | Port 0 interface mode |
| p0_vphy_fdx | input | 1 | Port 0 emulated-PHY full duplex |
| p1_mode | input | 3 | Port 1 interface mode |
| p1_spd100 | input | 1 | Port 1 runs at 100 Mbps |
| p1_fdx | input | 1 | Port 1 full duplex |
| p1_link | input | 1 | Port 1 link up |
| p1_lcl_eee | input | 1 | Port 1 local EEE-100 ability |
| p1_lp_eee | input | 1 | Port 1 partner EEE-100 ability |
| p2_mode | input | 3 | Port 2 interface mode |
| p2_spd100 | input | 1 | Port 2 runs at 100 Mbps |
| p2_fdx | input | 1 | Port 2 full duplex |
| p2_link | input | 1 | Port 2 link up |
| p2_lcl_eee | input | 1 | Port 2 local EEE-100 ability |
| p2_lp_eee | input | 1 | Port 2 partner EEE-100 ability |
| eee_allowed | output | 3 | Per-port EEE qualification |

## Verification
The bench builds the block with `TICK_LIMIT` set to 4 instead of 1000. This lets it step through every tick count of the stable-link window, the saturation point and the restart after a link drop in a few dozen cycles. With both links saturated, it then sweeps every combination of enable, all eight mode codes and the four speed/duplex/ability bits on ports 1 and 2. It also sweeps every combination of enable, mode and duplex on port 0. Expected values are computed directly from the rule formulas.

// File: rtl/eee_qual_pkg.sv
package eee_qual_pkg;

  typedef enum logic [2:0] {
    MODE_INT_PHY  = 3'd0,
    MODE_MII_MAC  = 3'd1,
    MODE_MII_PHY  = 3'd2,
    MODE_RMII_MAC = 3'd3,
    MODE_RMII_PHY = 3'd4
  } port_mode_e;

  typedef enum logic [1:0] {
    RULE_VPHY_MAC = 2'd0,
    RULE_INT_ONLY = 2'd1,
    RULE_GENERAL  = 2'd2
  } rule_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       spd100;
    logic       fdx;
    logic       link;
    logic       lcl_eee;
    logic       lp_eee;
  } port_status_t;

  localparam int unsigned NUM_PORTS = 3;

  function automatic rule_e rule_for(input int unsigned port);
    rule_e r;
    case (port)
      0:       r = RULE_VPHY_MAC;
      1:       r = RULE_INT_ONLY;
      default: r = RULE_GENERAL;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eee_rst_sync.sv
module eee_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/eee_link_timer.sv
module eee_link_timer #(
  parameter int unsigned TICK_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic link_up,
  output logic stable
);

  localparam int unsigned CNT_W = $clog2(TICK_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICK_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!link_up) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (tick && (cnt_q != LIMIT)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign stable = link_up && (cnt_q == LIMIT);

endmodule

// File: rtl/eee_port_rule.sv
module eee_port_rule
  import eee_qual_pkg::*;
#(
  parameter rule_e RULE = RULE_GENERAL
) (
  input  port_status_t st,
  input  logic         link_stable,
  output logic         rule_ok
);

  logic mode_ok;
  logic phy_ok;

  generate
    if (RULE == RULE_VPHY_MAC) begin : g_vphy
      assign mode_ok = (st.mode == MODE_MII_MAC);
    end else if (RULE == RULE_INT_ONLY) begin : g_int
      assign mode_ok = (st.mode == MODE_INT_PHY);
    end else begin : g_gen
      assign mode_ok = (st.mode == MODE_INT_PHY) || (st.mode == MODE_MII_MAC);
    end
  endgenerate

  assign phy_ok = st.spd100 && st.lcl_eee && st.lp_eee && st.link && link_stable;

  assign rule_ok = mode_ok && st.fdx && ((RULE == RULE_VPHY_MAC) ? 1'b1 : phy_ok);

endmodule

// File: rtl/eee_qual.sv
module eee_qual
  import eee_qual_pkg::*;
#(
  parameter int unsigned TICK_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1khz,
  input  logic [2:0] sw_en,
  input  logic [2:0] p0_mode,
  input  logic       p0_vphy_fdx,
  input  logic [2:0] p1_mode,
  input  logic       p1_spd100,
  input  logic       p1_fdx,
  input  logic       p1_link,
  input  logic       p1_lcl_eee,
  input  logic       p1_lp_eee,
  input  logic [2:0] p2_mode,
  input  logic       p2_spd100,
  input  logic       p2_fdx,
  input  logic       p2_link,
  input  logic       p2_lcl_eee,
  input  logic       p2_lp_eee,
  output logic [2:0] eee_allowed
);

  logic                 rst_n_sync;
  port_status_t         st     [NUM_PORTS];
  logic [NUM_PORTS-1:0] stable;
  logic [NUM_PORTS-1:0] rule_ok;

  eee_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  // Port 0 has no PHY-side status: those fields are tied to their passing level.
  assign st[0] = '{mode: p0_mode, spd100: 1'b1, fdx: p0_vphy_fdx,
                   link: 1'b1, lcl_eee: 1'b1, lp_eee: 1'b1};
  assign st[1] = '{mode: p1_mode, spd100: p1_spd100, fdx: p1_fdx,
                   link: p1_link, lcl_eee: p1_lcl_eee, lp_eee: p1_lp_eee};
  assign st[2] = '{mode: p2_mode, spd100: p2_spd100, fdx: p2_fdx,
                   link: p2_link, lcl_eee: p2_lcl_eee, lp_eee: p2_lp_eee};

  assign stable[0] = 1'b1;

  generate
    for (genvar p = 1; p < NUM_PORTS; p++) begin : g_timer
      eee_link_timer #(.TICK_LIMIT(TICK_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n_sync),
        .tick   (tick_1khz),
        .link_up(st[p].link),
        .stable (stable[p])
      );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rule
      eee_port_rule #(.RULE(rule_for(p))) u_rule (
        .st         (st[p]),
        .link_stable(stable[p]),
        .rule_ok    (rule_ok[p])
      );
    end
  endgenerate

  assign eee_allowed = rule_ok & sw_en & {NUM_PORTS{rst_n_sync}};

endmodule

// File: rtl/eee_qual_chk.sv
module eee_qual_chk
  import eee_qual_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sw_en,
  input logic [2:0] p0_mode,
  input logic [2:0] p1_mode,
  input logic       p1_link,
  input logic [2:0] p2_mode,
  input logic       p2_link,
  input logic [2:0] eee_allowed
);

  assert_p0_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_mode != MODE_MII_MAC) |-> !eee_allowed[0]);

  assert_p1_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_mode != MODE_INT_PHY) |-> !eee_allowed[1]);

  assert_p2_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((p2_mode != MODE_INT_PHY) && (p2_mode != MODE_MII_MAC)) |-> !eee_allowed[2]);

  assert_sw_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|eee_allowed) |-> ((eee_allowed & ~sw_en) == 3'b000));

  assert_p1_rise_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eee_allowed[1]) |-> $past(p1_link));

  assert_p1_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !p1_link |-> !eee_allowed[1]);

  assert_p2_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !p2_link |-> !eee_allowed[2]);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (eee_allowed == 3'b000));

endmodule

bind eee_qual eee_qual_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_en      (sw_en),
  .p0_mode    (p0_mode),
  .p1_mode    (p1_mode),
  .p1_link    (p1_link),
  .p2_mode    (p2_mode),
  .p2_link    (p2_link),
  .eee_allowed(eee_allowed)
);

// File: tb/eee_qual_tb.sv
module eee_qual_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1khz;
  logic [2:0] sw_en;
  logic [2:0] p0_mode;
  logic       p0_vphy_fdx;
  logic [2:0] p1_mode;
  logic       p1_spd100, p1_fdx, p1_link, p1_lcl_eee, p1_lp_eee;
  logic [2:0] p2_mode;
  logic       p2_spd100, p2_fdx, p2_link, p2_lcl_eee, p2_lp_eee;
  logic [2:0] eee_allowed;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eee_qual #(.TICK_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1khz(tick_1khz), .sw_en(sw_en),
    .p0_mode(p0_mode), .p0_vphy_fdx(p0_vphy_fdx),
    .p1_mode(p1_mode), .p1_spd100(p1_spd100), .p1_fdx(p1_fdx), .p1_link(p1_link),
    .p1_lcl_eee(p1_lcl_eee), .p1_lp_eee(p1_lp_eee),
    .p2_mode(p2_mode), .p2_spd100(p2_spd100), .p2_fdx(p2_fdx), .p2_link(p2_link),
    .p2_lcl_eee(p2_lcl_eee), .p2_lp_eee(p2_lp_eee),
    .eee_allowed(eee_allowed)
  );

  task automatic chk(input string tag, input int port, input logic exp);
    n_vec++;
    if (eee_allowed[port] !== exp) begin
      n_bad++;
      $display("FAIL %s port%0d actual=%b expected=%b", tag, port, eee_allowed[port], exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_1khz = 1'b1;
    @(negedge clk) tick_1khz = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_1khz = 1'b1; sw_en = 3'b111;
    p0_mode = 3'd1; p0_vphy_fdx = 1'b1;
    p1_mode = 3'd0; {p1_spd100, p1_fdx, p1_link, p1_lcl_eee, p1_lp_eee} = 5'b11111;
    p2_mode = 3'd0; {p2_spd100, p2_fdx, p2_link, p2_lcl_eee, p2_lp_eee} = 5'b11111;
    repeat (4) @(negedge clk);
    #1;
    for (int p = 0; p < 3; p++) chk("R9 reset", p, 1'b0);

    @(negedge clk) begin rst_n = 1'b1; tick_1khz = 1'b0; p1_link = 1'b0; p2_link = 1'b0; end
    repeat (4) @(negedge clk);
    #1;
    chk("R1 after reset", 0, 1'b1);

    // R6: ticks with link down are not counted
    for (int i = 0; i < 3; i++) pulse_tick();
    @(negedge clk) p1_link = 1'b1;
    #1;
    chk("R6 ticks while down ignored", 1, 1'b0);
    repeat (8) @(negedge clk);
    #1;
    chk("R6 idle cycles do not count", 1, 1'b0);
    for (int i = 1; i <= LIM; i++) begin
      pulse_tick();
      chk("R6 stable window", 1, (i == LIM));
      chk("R1 port0 unaffected by ticks", 0, 1'b1);
    end
    // R8: saturation
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      chk("R8 saturated", 1, 1'b1);
    end
    // R7: same-cycle drop and restart
    @(negedge clk) p1_link = 1'b0;
    #1;
    chk("R7 same-cycle drop", 1, 1'b0);
    @(negedge clk) p1_link = 1'b1;
    #1;
    chk("R7 restart from zero", 1, 1'b0);
    for (int i = 1; i <= LIM; i++) begin
      pulse_tick();
      chk("R7 full window again", 1, (i == LIM));
    end

    // bring port 2 into saturation
    @(negedge clk) p2_link = 1'b1;
    for (int i = 0; i < LIM + 2; i++) pulse_tick();
    chk("R4 port2 stable", 2, 1'b1);

    // Port 1 sweep
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk) begin
            sw_en[1] = s[0]; p1_mode = m[2:0];
            {p1_spd100, p1_fdx, p1_lcl_eee, p1_lp_eee} = b[3:0];
          end
          #1;
          chk((s == 0) ? "R5 port1 disabled" : "R3 port1 rule", 1,
              (s == 1) && (m == 0) && (b == 15));
        end
    @(negedge clk) begin sw_en[1] = 1'b1; p1_mode = 3'd0;
      {p1_spd100, p1_fdx, p1_lcl_eee, p1_lp_eee} = 4'hF; end

    // Port 2 sweep
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk) begin
            sw_en[2] = s[0]; p2_mode = m[2:0];
            {p2_spd100, p2_fdx, p2_lcl_eee, p2_lp_eee} = b[3:0];
          end
          #1;
          chk((s == 0) ? "R5 port2 disabled" : "R4 port2 rule", 2,
              (s == 1) && (m <= 1) && (b == 15));
        end
    @(negedge clk) p2_link = 1'b0;
    #1;
    chk("R7 port2 drop", 2, 1'b0);

    // Port 0 sweep, with port 1 inputs changing alongside
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++)
        for (int f = 0; f < 2; f++) begin
          @(negedge clk) begin
            sw_en[0] = s[0]; p0_mode = m[2:0]; p0_vphy_fdx = f[0];
            p1_link = m[0]; p1_mode = m[2:0];
          end
          #1;
          chk((s == 0) ? "R5 port0 disabled" : ((m == 1) ? "R1 port0 rule" : "R2 port0 mode"),
              0, (s == 1) && (m == 1) && (f == 1));
        end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule